// File: doc/BRIEF.md
# Per-Channel DMA Word Packer

This block sits between a memory port that moves only whole 32-bit words and a peripheral port that moves narrow units. Each channel has its own lane. On the transmit lane a word taken from memory is split into a sequence of narrow units. On the receive lane narrow units from the device are collected into a word for memory. Each channel holds two settings: whether its narrow units are bytes or halfwords, and whether it treats a word as big-endian or little-endian. Together these fix which bits of the word each narrow unit occupies.

Both sides of every lane use valid/ready handshakes. Units within a word are always transferred in rising address order, starting at offset 0. A per-channel flush input pushes out a partly filled receive word. The lanes that were not filled read as zero, and a byte-enable mask marks the lanes that were filled. A channel's settings can be changed only while both of its lanes are empty. Requests made at other times are dropped.

Top module: `dma_word_packer`

## Requirements
- R1: Each 32-bit word accepted on a transmit lane yields exactly four device transfers in byte mode and two in halfword mode. A new word is accepted while the lane is empty or during the handshake of its last unit.
- R2: In little-endian byte mode, unit k (k = 0..3, in transfer order) is word bits 8k+7:8k. Bytes travel on the device data bits 7:0, and bits 15:8 are zero.
- R3: In big-endian byte mode, unit 0 is word bits 31:24, and unit 3 is bits 7:0.
- R4: In halfword mode, unit 0 is bits 15:0 when little-endian and bits 31:16 when big-endian. Unit 1 is the other half.
- R5: On receive, a memory word is offered only after four bytes (byte mode) or two halfwords (halfword mode) have been collected. Its byte enable is 4'b1111. The device side is not ready while a word waits for memory.
- R6: A flush pulse on a partly filled receive lane offers the partial word. Unfilled byte lanes are zero, and the byte-enable bit n is 1 exactly when byte n (bits 8n+7:8n) holds received data.
- R7: A flush on an empty receive lane has no effect: no memory word is offered.
- R8: When a flush and a device unit are accepted in the same cycle, the unit is stored first and the flush then applies, so the offered word contains that unit.
- R9: A configuration write (cfg_big: 1 = big-endian, cfg_half: 1 = halfword) to a channel takes effect only when both lanes of that channel are empty. Otherwise it is ignored.
- R10: Channels are independent: each channel's settings and lanes affect no other channel.
- R11: After reset every channel is little-endian byte mode. No valid output is asserted, and both input-side readies are high.
- R12: While an output is valid and not taken, its valid, data and byte enable stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel targeted by the configuration write |
| cfg_big | input | 1 | 1 = big-endian |
| cfg_half | input | 1 | 1 = halfword units, 0 = byte units |
| mem_tx_valid | input | NUM_CH | Memory word offered to transmit lane |
| mem_tx_ready | output | NUM_CH | Transmit lane can take a word |
| mem_tx_data | input | NUM_CH*32 | Memory words, channel i at bits 32i+31:32i |
| dev_tx_valid | output | NUM_CH | Narrow unit offered to the device |
| dev_tx_ready | input | NUM_CH | Device takes the unit |
| dev_tx_data | output | NUM_CH*16 | Narrow units, channel i at bits 16i+15:16i |
| dev_rx_valid | input | NUM_CH | Device offers a narrow unit |
| dev_rx_ready | output | NUM_CH | Receive lane can take a unit |
| dev_rx_data | input | NUM_CH*16 | Device units (byte mode uses bits 7:0 of each slice) |
| rx_flush | input | NUM_CH | Push out a partly filled receive word |
| mem_rx_valid | output | NUM_CH | Assembled word offered to memory |
| mem_rx_ready | input | NUM_CH | Memory takes the word |
| mem_rx_data | output | NUM_CH*32 | Assembled words |
| mem_rx_be | output | NUM_CH*4 | Byte enables, bit n covers bits 8n+7:8n |

## Verification
Two pairs of events can fall in the same cycle. The first is a flush arriving with a device unit. The bench raises both in the same handshake cycle, once on the second byte and once on the fourth byte of a word. It expects a two-byte partial word in the first case and a complete word with full enables in the second. The second pair is a configuration write arriving while a lane holds data. The bench issues the write between receive bytes, and separately while a stalled transmit word is held. It then judges from the unit order and the assembled word that the old setting stayed in force.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WORD_W = 32;
  localparam int UNIT_W = 16;
  localparam int LANES  = WORD_W / 8;

  // number of narrow units per word
  function automatic logic [2:0] units_per_word(input logic half);
    return half ? 3'd2 : 3'd4;
  endfunction

  // lowest byte lane occupied by unit idx
  function automatic logic [1:0] byte_slot(input logic [1:0] idx, input logic big,
                                           input logic half);
    logic hpos;
    if (half) begin
      hpos = big ? ~idx[0] : idx[0];
      return {hpos, 1'b0};
    end
    return big ? (2'd3 - idx) : idx;
  endfunction

  function automatic logic [UNIT_W-1:0] lane_pick(input logic [WORD_W-1:0] word,
                                                  input logic [1:0] idx, input logic big,
                                                  input logic half);
    logic [4:0]        sh;
    logic [WORD_W-1:0] shifted;
    sh      = {byte_slot(idx, big, half), 3'b000};
    shifted = word >> sh;
    return half ? shifted[15:0] : {8'h00, shifted[7:0]};
  endfunction

  function automatic logic [WORD_W-1:0] lane_place(input logic [UNIT_W-1:0] unit,
                                                   input logic [1:0] idx, input logic big,
                                                   input logic half);
    logic [4:0]        sh;
    logic [WORD_W-1:0] ext;
    sh  = {byte_slot(idx, big, half), 3'b000};
    ext = half ? {16'h0000, unit} : {24'h000000, unit[7:0]};
    return ext << sh;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] idx, input logic big,
                                                 input logic half);
    logic [LANES-1:0] m;
    m = half ? 4'b0011 : 4'b0001;
    return m << byte_slot(idx, big, half);
  endfunction
endpackage

// File: rtl/wp_cfg.sv
module wp_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic big_in,
  input  logic half_in,
  input  logic idle,
  output logic big,
  output logic half
);
  logic take_cfg;
  assign take_cfg = wr && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      big  <= 1'b0;
      half <= 1'b0;
    end else if (take_cfg) begin
      big  <= big_in;
      half <= half_in;
    end
  end
endmodule

// File: rtl/wp_unpack.sv
module wp_unpack
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big,
  input  logic              half,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [UNIT_W-1:0] out_data,
  output logic              empty
);
  logic              full;
  logic [WORD_W-1:0] word_q;
  logic [1:0]        idx;
  logic              unit_fire, unit_last, word_take;

  assign unit_fire = full && out_ready;
  assign unit_last = ({1'b0, idx} == units_per_word(half) - 3'd1);
  assign in_ready  = !full || (unit_fire && unit_last);
  assign word_take = in_valid && in_ready;
  assign out_valid = full;
  assign out_data  = lane_pick(word_q, idx, big, half);
  assign empty     = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      word_q <= '0;
      idx    <= '0;
    end else if (word_take) begin
      full   <= 1'b1;
      word_q <= in_data;
      idx    <= '0;
    end else if (unit_fire) begin
      if (unit_last) full <= 1'b0;
      else           idx  <= idx + 2'd1;
    end
  end
endmodule

// File: rtl/wp_pack.sv
module wp_pack
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big,
  input  logic              half,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [UNIT_W-1:0] in_data,
  input  logic              flush,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [LANES-1:0]  out_be,
  output logic              empty
);
  logic              pend;
  logic [WORD_W-1:0] acc;
  logic [LANES-1:0]  be_q;
  logic [2:0]        idx, idx_nx;
  logic              unit_take, seal;
  logic [WORD_W-1:0] acc_nx;
  logic [LANES-1:0]  be_nx;

  assign in_ready  = !pend;
  assign unit_take = in_valid && in_ready;

  always_comb begin
    acc_nx = acc;
    be_nx  = be_q;
    idx_nx = idx;
    if (unit_take) begin
      acc_nx = acc  | lane_place(in_data, idx[1:0], big, half);
      be_nx  = be_q | lane_mask(idx[1:0], big, half);
      idx_nx = idx + 3'd1;
    end
  end

  // word closes when full, or when flushed with at least one unit inside
  assign seal = !pend && ((idx_nx == units_per_word(half)) || (flush && idx_nx != 3'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      acc  <= '0;
      be_q <= '0;
      idx  <= '0;
    end else if (pend) begin
      if (out_ready) begin
        pend <= 1'b0;
        acc  <= '0;
        be_q <= '0;
        idx  <= '0;
      end
    end else begin
      acc  <= acc_nx;
      be_q <= be_nx;
      idx  <= idx_nx;
      pend <= seal;
    end
  end

  assign out_valid = pend;
  assign out_data  = acc;
  assign out_be    = be_q;
  assign empty     = !pend && (idx == 3'd0);
endmodule

// File: rtl/dma_word_packer.sv
module dma_word_packer #(
  parameter  int NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CH_W-1:0]      cfg_ch,
  input  logic                 cfg_big,
  input  logic                 cfg_half,
  input  logic [NUM_CH-1:0]    mem_tx_valid,
  output logic [NUM_CH-1:0]    mem_tx_ready,
  input  logic [NUM_CH*32-1:0] mem_tx_data,
  output logic [NUM_CH-1:0]    dev_tx_valid,
  input  logic [NUM_CH-1:0]    dev_tx_ready,
  output logic [NUM_CH*16-1:0] dev_tx_data,
  input  logic [NUM_CH-1:0]    dev_rx_valid,
  output logic [NUM_CH-1:0]    dev_rx_ready,
  input  logic [NUM_CH*16-1:0] dev_rx_data,
  input  logic [NUM_CH-1:0]    rx_flush,
  output logic [NUM_CH-1:0]    mem_rx_valid,
  input  logic [NUM_CH-1:0]    mem_rx_ready,
  output logic [NUM_CH*32-1:0] mem_rx_data,
  output logic [NUM_CH*4-1:0]  mem_rx_be
);
  // per-channel state brought out for the checker
  logic [NUM_CH-1:0] tx_empty_v, rx_empty_v, cfg_big_v, cfg_half_v;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic big_i, half_i, txe, rxe, hit;
    assign hit = cfg_we && (cfg_ch == CH_W'(i));

    wp_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(hit), .big_in(cfg_big), .half_in(cfg_half),
      .idle(txe && rxe), .big(big_i), .half(half_i)
    );

    wp_unpack u_tx (
      .clk(clk), .rst_n(rst_n), .big(big_i), .half(half_i),
      .in_valid(mem_tx_valid[i]), .in_ready(mem_tx_ready[i]),
      .in_data(mem_tx_data[i*32 +: 32]),
      .out_valid(dev_tx_valid[i]), .out_ready(dev_tx_ready[i]),
      .out_data(dev_tx_data[i*16 +: 16]), .empty(txe)
    );

    wp_pack u_rx (
      .clk(clk), .rst_n(rst_n), .big(big_i), .half(half_i),
      .in_valid(dev_rx_valid[i]), .in_ready(dev_rx_ready[i]),
      .in_data(dev_rx_data[i*16 +: 16]), .flush(rx_flush[i]),
      .out_valid(mem_rx_valid[i]), .out_ready(mem_rx_ready[i]),
      .out_data(mem_rx_data[i*32 +: 32]), .out_be(mem_rx_be[i*4 +: 4]),
      .empty(rxe)
    );

    assign tx_empty_v[i] = txe;
    assign rx_empty_v[i] = rxe;
    assign cfg_big_v[i]  = big_i;
    assign cfg_half_v[i] = half_i;
  end
endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
  parameter int NUM_CH = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CH-1:0]    mem_tx_ready,
  input logic [NUM_CH-1:0]    dev_tx_valid,
  input logic [NUM_CH-1:0]    dev_tx_ready,
  input logic [NUM_CH*16-1:0] dev_tx_data,
  input logic [NUM_CH-1:0]    dev_rx_ready,
  input logic [NUM_CH-1:0]    mem_rx_valid,
  input logic [NUM_CH-1:0]    mem_rx_ready,
  input logic [NUM_CH*32-1:0] mem_rx_data,
  input logic [NUM_CH*4-1:0]  mem_rx_be,
  input logic [NUM_CH-1:0]    tx_empty_v,
  input logic [NUM_CH-1:0]    rx_empty_v,
  input logic [NUM_CH-1:0]    cfg_big_v,
  input logic [NUM_CH-1:0]    cfg_half_v
);
  function automatic logic [31:0] be_bits(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dev_tx_valid[i] && !dev_tx_ready[i] |=> dev_tx_valid[i] && $stable(dev_tx_data[i*16 +: 16])); // R12
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rx_valid[i] && !mem_rx_ready[i] |=> mem_rx_valid[i] && $stable(mem_rx_data[i*32 +: 32])
        && $stable(mem_rx_be[i*4 +: 4])); // R12
    AST_RX_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rx_valid[i] |-> mem_rx_be[i*4 +: 4] != 4'b0000); // R6
    AST_RX_ZERO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rx_valid[i] |-> (mem_rx_data[i*32 +: 32] & ~be_bits(mem_rx_be[i*4 +: 4])) == 32'h0); // R6
    AST_RX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rx_valid[i] |-> !dev_rx_ready[i]); // R5
    AST_TX_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty_v[i] |-> mem_tx_ready[i] && !dev_tx_valid[i]); // R1
    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_big_v[i]) || !$stable(cfg_half_v[i]) |-> $past(tx_empty_v[i] && rx_empty_v[i])); // R9
  end
endmodule

bind dma_word_packer wp_checker #(.NUM_CH(NUM_CH)) u_wp_checker (.*);

// File: tb/tb_dma_word_packer.sv
module tb_dma_word_packer;
  localparam int CLK_P = 10;
  localparam int NCH   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [0:0]      cfg_ch = '0;
  logic            cfg_big = 1'b0, cfg_half = 1'b0;
  logic [NCH-1:0]  mem_tx_valid = '0, mem_tx_ready;
  logic [NCH*32-1:0] mem_tx_data = '0;
  logic [NCH-1:0]  dev_tx_valid, dev_tx_ready = '1;
  logic [NCH*16-1:0] dev_tx_data;
  logic [NCH-1:0]  dev_rx_valid = '0, dev_rx_ready;
  logic [NCH*16-1:0] dev_rx_data = '0;
  logic [NCH-1:0]  rx_flush = '0;
  logic [NCH-1:0]  mem_rx_valid, mem_rx_ready = '1;
  logic [NCH*32-1:0] mem_rx_data;
  logic [NCH*4-1:0]  mem_rx_be;

  always #(CLK_P/2) clk = ~clk;

  dma_word_packer #(.NUM_CH(NCH)) dut (.*);

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] txq0[$], txq1[$];
  logic [35:0] rxq0[$], rxq1[$];
  int tx_cnt[NCH];
  logic cbig[NCH], chalf[NCH];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench's own view of the unit order
  function automatic logic [15:0] exp_unit(input logic [31:0] w, input int k, input logic big, input logic half);
    int pos;
    if (half) begin
      pos = big ? 1 - k : k;
      return w[pos*16 +: 16];
    end
    pos = big ? 3 - k : k;
    return {8'h00, w[pos*8 +: 8]};
  endfunction

  function automatic logic [35:0] exp_word(input logic [63:0] u, input int n, input logic big, input logic half);
    logic [31:0] d = '0;
    logic [3:0]  b = '0;
    for (int k = 0; k < n; k++) begin
      int pos;
      if (half) begin
        pos = big ? 1 - k : k;
        d[pos*16 +: 16] = u[k*16 +: 16];
        b[pos*2 +: 2] = 2'b11;
      end else begin
        pos = big ? 3 - k : k;
        d[pos*8 +: 8] = u[k*16 +: 8];
        b[pos] = 1'b1;
      end
    end
    return {b, d};
  endfunction

  // monitor: compares every completed handshake against the scoreboard
  always @(negedge clk) if (rst_n) begin
    for (int c = 0; c < NCH; c++) begin
      if (dev_tx_valid[c] && dev_tx_ready[c]) begin
        logic [15:0] e;
        tx_cnt[c]++;
        if ((c == 0 ? txq0.size() : txq1.size()) == 0)
          check(0, "R1 unexpected unit", {48'h0, dev_tx_data[c*16 +: 16]}, 64'h0);
        else begin
          e = (c == 0) ? txq0.pop_front() : txq1.pop_front();
          check(dev_tx_data[c*16 +: 16] == e, "R2/R3/R4/R10 tx unit", {48'h0, dev_tx_data[c*16 +: 16]}, {48'h0, e});
        end
      end
      if (mem_rx_valid[c] && mem_rx_ready[c]) begin
        logic [35:0] e, a;
        a = {mem_rx_be[c*4 +: 4], mem_rx_data[c*32 +: 32]};
        if ((c == 0 ? rxq0.size() : rxq1.size()) == 0)
          check(0, "R5/R7 unexpected word", {28'h0, a}, 64'h0);
        else begin
          e = (c == 0) ? rxq0.pop_front() : rxq1.pop_front();
          check(a == e, "R5/R6/R8/R10 rx word", {28'h0, a}, {28'h0, e});
        end
      end
    end
  end

  task automatic cfg_write(input int ch, input logic big, input logic half);
    @(posedge clk); #1;
    cfg_we = 1; cfg_ch = ch[0:0]; cfg_big = big; cfg_half = half;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic send_word(input int ch, input logic [31:0] w);
    for (int k = 0; k < (chalf[ch] ? 2 : 4); k++)
      if (ch == 0) txq0.push_back(exp_unit(w, k, cbig[ch], chalf[ch]));
      else         txq1.push_back(exp_unit(w, k, cbig[ch], chalf[ch]));
    @(posedge clk); #1;
    mem_tx_valid[ch] = 1; mem_tx_data[ch*32 +: 32] = w;
    forever begin
      @(negedge clk);
      if (mem_tx_ready[ch]) break;
    end
    @(posedge clk); #1;
    mem_tx_valid[ch] = 0;
  endtask

  task automatic send_unit(input int ch, input logic [15:0] d, input bit fl);
    @(posedge clk); #1;
    dev_rx_valid[ch] = 1; dev_rx_data[ch*16 +: 16] = d; rx_flush[ch] = fl;
    forever begin
      @(negedge clk);
      if (dev_rx_ready[ch]) break;
    end
    @(posedge clk); #1;
    dev_rx_valid[ch] = 0; rx_flush[ch] = 0;
  endtask

  task automatic pulse_flush(input int ch);
    @(posedge clk); #1; rx_flush[ch] = 1;
    @(posedge clk); #1; rx_flush[ch] = 0;
  endtask

  task automatic drain(input string req);
    int t = 0;
    while ((txq0.size() + txq1.size() + rxq0.size() + rxq1.size()) != 0 && t < 60) begin
      @(negedge clk); t++;
    end
    check(t < 60, req, 64'(txq0.size() + txq1.size() + rxq0.size() + rxq1.size()), 64'h0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    logic [15:0] held;
    for (int c = 0; c < NCH; c++) begin cbig[c] = 0; chalf[c] = 0; tx_cnt[c] = 0; end
    repeat (3) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(dev_tx_valid == 0 && mem_rx_valid == 0, "R11 valids low", {62'h0, dev_tx_valid | mem_rx_valid}, 64'h0);
    check(mem_tx_ready == 2'b11 && dev_rx_ready == 2'b11, "R11 readies high", {60'h0, mem_tx_ready, dev_rx_ready}, 64'hF);

    // R2 and R1: little-endian bytes, two words back to back
    c0 = tx_cnt[0];
    send_word(0, 32'h44332211);
    send_word(0, 32'h88776655);
    drain("R2 drain");
    check(tx_cnt[0] - c0 == 8, "R1 byte-mode unit count", 64'(tx_cnt[0] - c0), 64'd8);

    // R3: big-endian bytes
    cfg_write(0, 1, 0); cbig[0] = 1; chalf[0] = 0;
    send_word(0, 32'hA1B2C3D4);
    drain("R3 drain");

    // R4: halfwords, both orders, and R1 count
    cfg_write(0, 1, 1); chalf[0] = 1;
    c0 = tx_cnt[0];
    send_word(0, 32'h12345678);
    drain("R4 big drain");
    check(tx_cnt[0] - c0 == 2, "R1 half-mode unit count", 64'(tx_cnt[0] - c0), 64'd2);
    cfg_write(0, 0, 1); cbig[0] = 0;
    send_word(0, 32'h9ABCDEF0);
    drain("R4 little drain");

    // R12: device stalls the transmit unit
    dev_tx_ready[0] = 0;
    send_word(0, 32'hCAFEF00D);
    @(negedge clk); held = dev_tx_data[15:0];
    repeat (3) @(negedge clk);
    check(dev_tx_valid[0] && dev_tx_data[15:0] == held, "R12 tx held", {48'h0, dev_tx_data[15:0]}, {48'h0, held});
    // R9: configuration while transmit lane busy is dropped
    cfg_write(0, 1, 0);
    @(posedge clk); #1; dev_tx_ready[0] = 1;
    drain("R9 tx busy drain");
    send_word(0, 32'h0BADBEEF);   // still little-endian halfwords
    drain("R9 tx after drop");

    // R5: four bytes make a word, none before
    cfg_write(0, 0, 0); cbig[0] = 0; chalf[0] = 0;
    send_unit(0, 16'h00A0, 0); send_unit(0, 16'h00A1, 0); send_unit(0, 16'h00A2, 0);
    @(negedge clk);
    check(mem_rx_valid[0] == 0, "R5 no word after three bytes", {63'h0, mem_rx_valid[0]}, 64'h0);
    rxq0.push_back(exp_word(64'h00A3_00A2_00A1_00A0, 4, 0, 0));
    send_unit(0, 16'h00A3, 0);
    drain("R5 drain");

    // R5/R12: memory stalls, device side blocked
    mem_rx_ready[0] = 0;
    send_unit(0, 16'h0001, 0); send_unit(0, 16'h0002, 0);
    send_unit(0, 16'h0003, 0); send_unit(0, 16'h0004, 0);
    repeat (2) @(negedge clk);
    check(mem_rx_valid[0] && !dev_rx_ready[0], "R5 device blocked while word waits",
          {62'h0, mem_rx_valid[0], dev_rx_ready[0]}, 64'h2);
    check({mem_rx_be[3:0], mem_rx_data[31:0]} == exp_word(64'h0004_0003_0002_0001, 4, 0, 0),
          "R12 rx word held", {28'h0, mem_rx_be[3:0], mem_rx_data[31:0]}, 64'h0);
    rxq0.push_back(exp_word(64'h0004_0003_0002_0001, 4, 0, 0));
    @(posedge clk); #1; mem_rx_ready[0] = 1;
    drain("R5 stall drain");

    // R6: flush partial, little bytes then big halfwords
    rxq0.push_back(exp_word(64'h0000_0000_0022_0011, 2, 0, 0));
    send_unit(0, 16'h0011, 0); send_unit(0, 16'h0022, 0);
    pulse_flush(0);
    drain("R6 byte flush");
    cfg_write(0, 1, 1); cbig[0] = 1; chalf[0] = 1;
    rxq0.push_back(exp_word(64'h0000_0000_0000_BEEF, 1, 1, 1));
    send_unit(0, 16'hBEEF, 0);
    pulse_flush(0);
    drain("R6 half flush");

    // R7: flush on empty lane
    pulse_flush(0);
    repeat (3) @(negedge clk);
    check(mem_rx_valid[0] == 0, "R7 flush on empty ignored", {63'h0, mem_rx_valid[0]}, 64'h0);

    // R8: flush in the same cycle as a unit
    cfg_write(0, 0, 0); cbig[0] = 0; chalf[0] = 0;
    rxq0.push_back(exp_word(64'h0000_0000_0066_0055, 2, 0, 0));
    send_unit(0, 16'h0055, 0); send_unit(0, 16'h0066, 1);
    drain("R8 flush with second byte");
    rxq0.push_back(exp_word(64'h0074_0073_0072_0071, 4, 0, 0));
    send_unit(0, 16'h0071, 0); send_unit(0, 16'h0072, 0);
    send_unit(0, 16'h0073, 0); send_unit(0, 16'h0074, 1);
    drain("R8 flush with last byte");
    repeat (2) @(negedge clk);
    check(mem_rx_valid[0] == 0, "R8 no extra word", {63'h0, mem_rx_valid[0]}, 64'h0);

    // R9: configuration write between receive bytes is dropped
    rxq0.push_back(exp_word(64'h0004_0003_0002_0001, 4, 0, 0));
    send_unit(0, 16'h0001, 0);
    cfg_write(0, 1, 1);
    send_unit(0, 16'h0002, 0); send_unit(0, 16'h0003, 0); send_unit(0, 16'h0004, 0);
    drain("R9 rx busy drop");

    // R10: channel 1 big bytes, channel 0 little halfwords
    cfg_write(1, 1, 0); cbig[1] = 1; chalf[1] = 0;
    cfg_write(0, 0, 1); cbig[0] = 0; chalf[0] = 1;
    send_word(1, 32'h11223344);
    send_word(0, 32'h11223344);
    drain("R10 tx drain");
    rxq1.push_back(exp_word(64'h0000_0000_0000_00EE, 1, 1, 0));
    send_unit(1, 16'h00EE, 1);
    drain("R10 rx drain");
    check(tx_cnt[1] == 4, "R10 channel 1 unit count", 64'(tx_cnt[1]), 64'd4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule